// File: doc/BRIEF.md
# GPIO Bank with Atomic Set/Clear Output Aliases

This block is a 32-pin general-purpose I/O bank. Software reaches it over a simple 32-bit memory-mapped register port with single-cycle read and write strobes. The bank holds a direction register, an output latch and a synchronized view of the pin levels. It also has a constant identification word. Two extra write-only addresses change chosen latch bits in one write. Software can then raise or drop single pins without a read-modify-write sequence, which could race with another writer.

The pads are modelled as three plain vectors: the value to drive, a per-pin direction flag and the sampled pin level. A direction bit of 1 turns the pin's driver off, so the pin is an input. A direction bit of 0 drives the latch value onto the pin. Bit p of every per-pin register belongs to pin p.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset, every direction bit is 1 (all pins are inputs), the output latch is 0, `pad_out` is 0 and `rd_data` is 0.
- R2: A read of byte offset 0x000 returns the constant 0x50600801.
- R3: Offset 0x134 holds the direction register. It is readable and writable, and `pad_dir_in` always equals it. A bit of 1 means the pin is an input and its driver is off. A bit of 0 means the pin drives the latch value.
- R4: Offset 0x13C holds the output latch. It is readable and writable, and `pad_out` always equals it.
- R5: A write to offset 0x194 sets every latch bit whose write-data bit is 1. Latch bits whose write-data bit is 0 keep their value.
- R6: A write to offset 0x190 clears every latch bit whose write-data bit is 1. Latch bits whose write-data bit is 0 keep their value.
- R7: Offset 0x138 returns `pad_in` after a two-flop synchronizer. Reads strobed at the first or second rising edge after a pin change return the old level. Reads strobed at the third edge or later return the new level. Writes to 0x138 are ignored.
- R8: Reads of 0x190, 0x194 and of any unmapped offset return 0. Writes to an unmapped offset or to 0x000 change neither the latch nor the direction register.
- R9: `rd_data` takes the selected value at the clock edge that samples `rd_en`, which is one cycle after the strobe is driven. It then holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 12 | Byte offset of the register |
| wr_data | input | 32 | Write data or bit mask |
| rd_data | output | 32 | Registered read data |
| pad_out | output | 32 | Value driven onto each pin |
| pad_dir_in | output | 32 | Per-pin direction, 1 = input (driver off) |
| pad_in | input | 32 | Raw pin levels |

## Verification
The hardest case to reach from the ports is the synchronizer edge. It shows only if the pin level and a read strobe change in the same half-cycle. The bench therefore changes `pad_in` and raises `rd_en` at the same falling edge, and expects the old level. It then repeats the read a few cycles later and expects the new level. Alias writes use masks that overlap set and cleared bits, and all-zero masks, so that any leak into unmasked bits shows on `pad_out`.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_ID    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h134;
  localparam logic [ADDR_W-1:0] OFS_LEVEL = 12'h138;
  localparam logic [ADDR_W-1:0] OFS_LATCH = 12'h13C;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h190;
  localparam logic [ADDR_W-1:0] OFS_SET   = 12'h194;

  localparam logic [DATA_W-1:0] ID_WORD = 32'h5060_0801;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_ID    = 3'd1,
    SEL_DIR   = 3'd2,
    SEL_LEVEL = 3'd3,
    SEL_LATCH = 3'd4,
    SEL_CLR   = 3'd5,
    SEL_SET   = 3'd6
  } reg_sel_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    unique case (addr)
      OFS_ID:    sel = SEL_ID;
      OFS_DIR:   sel = SEL_DIR;
      OFS_LEVEL: sel = SEL_LEVEL;
      OFS_LATCH: sel = SEL_LATCH;
      OFS_CLR:   sel = SEL_CLR;
      OFS_SET:   sel = SEL_SET;
      default:   sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_async;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] latch_q
);

  // Direction: 1 = input. Reset leaves every pin undriven.
  always_ff @(posedge clk) begin
    if (rst) dir_q <= '1;
    else if (wr_en && sel == SEL_DIR) dir_q <= wr_data;
  end

  // Output latch: direct write plus atomic set/clear aliases.
  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else if (wr_en) begin
      unique case (sel)
        SEL_LATCH: latch_q <= wr_data;
        SEL_SET:   latch_q <= latch_q | wr_data;
        SEL_CLR:   latch_q <= latch_q & ~wr_data;
        default:   latch_q <= latch_q;
      endcase
    end
  end

  p_set_alias_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_SET) |=>
      ((latch_q & $past(wr_data)) == $past(wr_data)) &&
      ((latch_q & ~$past(wr_data)) == ($past(latch_q) & ~$past(wr_data))));

  p_clr_alias_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CLR) |=>
      ((latch_q & $past(wr_data)) == '0) &&
      ((latch_q & ~$past(wr_data)) == ($past(latch_q) & ~$past(wr_data))));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_dir_in,
  input  logic [DATA_W-1:0] pad_in
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] level_sync;
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] latch_q;

  gpio_addr_dec u_dec (
    .addr (addr),
    .sel  (sel)
  );

  gpio_in_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pad_in),
    .q_sync  (level_sync)
  );

  gpio_out_regs #(.WIDTH(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .sel     (sel),
    .wr_data (wr_data),
    .dir_q   (dir_q),
    .latch_q (latch_q)
  );

  assign pad_out    = latch_q;
  assign pad_dir_in = dir_q;

  // Registered read mux; holds between reads.
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      unique case (sel)
        SEL_ID:    rd_data <= ID_WORD;
        SEL_DIR:   rd_data <= dir_q;
        SEL_LEVEL: rd_data <= level_sync;
        SEL_LATCH: rd_data <= latch_q;
        default:   rd_data <= '0;
      endcase
    end
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_dir_in == '1) && (pad_out == '0) && (rd_data == '0));

  p_id_read_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_ID) |=> (rd_data == ID_WORD));

  p_ignored_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (sel == SEL_NONE || sel == SEL_ID || sel == SEL_LEVEL)) |=>
      ($stable(pad_out) && $stable(pad_dir_in)));

  p_alias_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == OFS_SET || addr == OFS_CLR)) |=> (rd_data == '0));

  p_read_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] pad_out;
  logic [31:0] pad_dir_in;
  logic [31:0] pad_in = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  logic [31:0] m_dir, m_latch;

  always #5 clk = ~clk;

  gpio_bank dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pad_out(pad_out),
    .pad_dir_in(pad_dir_in), .pad_in(pad_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // Monitor: compare each read result against the scoreboard queue.
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9: unexpected read result %08h", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 dir reset", pad_dir_in, 32'hFFFF_FFFF);
    check("R1 latch reset", pad_out, 32'h0);
    check("R1 rd_data reset", rd_data, 32'h0);
    m_dir = 32'hFFFF_FFFF; m_latch = 32'h0;

    do_read(12'h000, 32'h5060_0801, "R2 id word");
    do_read(12'h134, m_dir, "R1 dir read after reset");

    // R3 direction register
    m_dir = 32'h0000_FFFF;
    do_write(12'h134, m_dir);
    check("R3 pad_dir_in", pad_dir_in, m_dir);
    do_read(12'h134, m_dir, "R3 dir readback");

    // R4 direct latch write
    m_latch = 32'hA5A5_5A5A;
    do_write(12'h13C, m_latch);
    check("R4 pad_out", pad_out, m_latch);
    do_read(12'h13C, m_latch, "R4 latch readback");

    // R5 set alias
    do_write(12'h194, 32'h0F0F_0000);
    m_latch = m_latch | 32'h0F0F_0000;
    check("R5 set mask", pad_out, m_latch);
    do_write(12'h194, 32'h0);
    check("R5 zero set mask", pad_out, m_latch);
    do_read(12'h13C, m_latch, "R5 latch after set");

    // R6 clear alias
    do_write(12'h190, 32'h8000_5A01);
    m_latch = m_latch & ~32'h8000_5A01;
    check("R6 clear mask", pad_out, m_latch);
    do_write(12'h190, 32'h0);
    check("R6 zero clear mask", pad_out, m_latch);
    do_read(12'h13C, m_latch, "R6 latch after clear");

    // R7 synchronizer timing: change pin and strobe on the same edge
    do_read(12'h138, 32'h0, "R7 level pre");
    @(negedge clk);
    pad_in = 32'h1234_5678;
    exp_q.push_back(32'h0); tag_q.push_back("R7 first edge old level");
    rd_en = 1'b1; addr = 12'h138;
    @(negedge clk);
    exp_q.push_back(32'h0); tag_q.push_back("R7 second edge old level");
    @(negedge clk);
    exp_q.push_back(32'h1234_5678); tag_q.push_back("R7 third edge new level");
    @(negedge clk);
    rd_en = 1'b0;
    do_write(12'h138, 32'hFFFF_FFFF);
    check("R7 level write ignored latch", pad_out, m_latch);
    check("R7 level write ignored dir", pad_dir_in, m_dir);
    do_read(12'h138, 32'h1234_5678, "R7 level after ignored write");

    // R8 alias/unmapped reads and ignored writes
    do_read(12'h190, 32'h0, "R8 clear alias reads zero");
    do_read(12'h194, 32'h0, "R8 set alias reads zero");
    do_read(12'h200, 32'h0, "R8 unmapped read zero");
    do_write(12'h200, 32'hFFFF_FFFF);
    do_write(12'h135, 32'hFFFF_FFFF);
    do_write(12'h000, 32'hFFFF_FFFF);
    check("R8 unmapped write latch", pad_out, m_latch);
    check("R8 unmapped write dir", pad_dir_in, m_dir);

    // R9 hold between reads
    do_read(12'h000, 32'h5060_0801, "R9 id before hold");
    repeat (4) @(negedge clk);
    check("R9 rd_data holds", rd_data, 32'h5060_0801);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: actual %0d pending reads expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule